// File: doc/BRIEF.md
# Lockstep Lane Datapath with Masked Branch Passes

This block is a small lockstep vector datapath. It has `LANES` lanes, 8 by default and up to 32. Each lane owns one 32-bit register. Reset loads every lane with its own lane number, so one instruction gives a different result in each lane. All lanes apply the same operation on the same clock edge, each to its own register. Two plain operations exist: add a constant and multiply by a constant.

A branch instruction holds three things: a threshold, a taken-path operation and a fall-through operation. Each lane computes its own predicate, which is "my value is below the threshold". If every lane agrees, only the path they all chose runs, and it takes one pass. If the lanes disagree, the taken path runs first with only the predicate-true lanes enabled. The fall-through path then runs on the next cycle with only the predicate-false lanes enabled. Lanes that are masked off keep their registers unchanged.

A `ready` flag, a one-cycle `done` pulse and a running pass counter make the cost of divergence visible at the ports.

Top module: `simt_branch_exec`

## Requirements
- R1: During and after reset, lane i holds the value i, `active_mask` is all ones, `ready` is 1, `done` is 0 and `pass_total` is 0.
- R2: With `op`=00 accepted (`issue` and `ready` high at a clock edge), every lane adds `imm` (modulo 2^32) on that edge, and `done` is high for the following cycle.
- R3: With `op`=01 accepted, every lane multiplies its value by `imm`, keeping the low 32 bits, on that edge, and `done` is high for the following cycle.
- R4: With `op`=1x (branch), the predicate of lane i is the unsigned compare value_i < `imm`. If the predicate is true in every lane, the taken operation runs on all lanes in one pass. `ready` stays high.
- R5: If the branch predicate is false in every lane, the fall-through operation runs on all lanes in one pass, and no empty taken pass is spent.
- R6: If the branch predicate is mixed, the accepting edge applies the taken operation to the true lanes only. `ready` is then low for exactly one cycle. The next edge applies the fall-through operation to the false lanes only, and `done` is then high. Example: reset values with threshold 4, taken add 100 and fall multiply 2 give 100,101,102,103,8,10,12,14.
- R7: A lane that is masked off in a pass keeps its register unchanged.
- R8: `active_mask` is all ones whenever `ready` is high. During the second pass of a divergent branch it equals the set of predicate-false lanes.
- R9: `pass_total` rises by one for each pass, so a uniform instruction adds 1 and a divergent branch adds 2.
- R10: `issue` is ignored while `ready` is low. The path operation select bits `taken_mul`/`fall_mul` mean 0 = add the constant and 1 = multiply by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Instruction valid |
| op | input | 2 | 00 add, 01 multiply, 1x branch |
| imm | input | 32 | Constant for add/multiply, or branch threshold |
| taken_mul | input | 1 | Taken path: 0 add, 1 multiply |
| taken_imm | input | 32 | Taken path constant |
| fall_mul | input | 1 | Fall-through path: 0 add, 1 multiply |
| fall_imm | input | 32 | Fall-through path constant |
| ready | output | 1 | Able to accept an instruction |
| done | output | 1 | One-cycle pulse when an instruction finishes |
| active_mask | output | LANES | Lanes enabled in the pending pass |
| pass_total | output | 32 | Running count of passes |
| lanes | output | LANES*32 | Lane registers, lane i at bits [32i+31:32i] |

## Verification
The datapath is exercised with add and multiply instructions, including a multiply whose product wraps. Branches are tried with a threshold above every lane, which separates the all-true case, and with a threshold of zero, which separates the all-false case. The mixed-predicate example shows whether the datapath serialises the two paths and masks the lanes correctly. A second instruction is held on `issue` during the second pass, which shows whether the busy cycle really ignores new work. A behavioural model is compared with the lanes, the mask, the handshake and the counter on every cycle.

// File: rtl/simt_branch_exec.sv
module simt_branch_exec #(
  parameter int LANES = 8,
  parameter int W     = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue,
  input  logic [1:0]         op,
  input  logic [W-1:0]       imm,
  input  logic               taken_mul,
  input  logic [W-1:0]       taken_imm,
  input  logic               fall_mul,
  input  logic [W-1:0]       fall_imm,
  output logic               ready,
  output logic               done,
  output logic [LANES-1:0]   active_mask,
  output logic [31:0]        pass_total,
  output logic [LANES*W-1:0] lanes
);

  logic [W-1:0]     v [LANES];
  logic [LANES-1:0] pred;
  logic             second;
  logic             fmul;
  logic [W-1:0]     fimm;

  function automatic logic [W-1:0] alu(input logic mul, input logic [W-1:0] a, input logic [W-1:0] k);
    return mul ? W'(a * k) : W'(a + k);
  endfunction

  assign ready = !second;

  wire accept    = issue && !second;
  wire is_br     = op[1];
  wire all_true  = &pred;
  wire none_true = ~|pred;
  wire diverge   = is_br && !all_true && !none_true;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign pred[i] = v[i] < imm;
    assign lanes[i*W +: W] = v[i];

    always_ff @(posedge clk) begin
      if (!rst_n) v[i] <= W'(i);
      else if (second) begin
        if (active_mask[i]) v[i] <= alu(fmul, v[i], fimm);
      end else if (accept) begin
        if (!is_br)         v[i] <= alu(op[0], v[i], imm);
        else if (pred[i])   v[i] <= alu(taken_mul, v[i], taken_imm);
        else if (none_true) v[i] <= alu(fall_mul, v[i], fall_imm);
      end
    end

    assert_masked_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (second && !active_mask[i]) |=> v[i] == $past(v[i]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      second      <= 1'b0;
      active_mask <= '1;
      done        <= 1'b0;
      pass_total  <= '0;
      fmul        <= 1'b0;
      fimm        <= '0;
    end else begin
      done <= 1'b0;
      if (second) begin
        second      <= 1'b0;
        active_mask <= '1;
        done        <= 1'b1;
        pass_total  <= pass_total + 1;
      end else if (accept) begin
        pass_total <= pass_total + 1;
        if (diverge) begin
          second      <= 1'b1;
          active_mask <= ~pred;
          fmul        <= fall_mul;
          fimm        <= fall_imm;
        end else begin
          done <= 1'b1;
        end
      end
    end
  end

  assert_reconverged_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> active_mask == '1);

  assert_partial_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (active_mask != '0 && active_mask != '1));

  assert_two_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |=> (ready && done));

  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_total == $past(pass_total)) || (pass_total == $past(pass_total) + 32'd1));

  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && issue) |=> ready);

endmodule

// File: tb/simt_branch_exec_test.sv
`timescale 1ns/1ps
module simt_branch_exec_test;
  localparam int LANES = 8;
  localparam int W = 32;

  logic clk = 0, rst_n = 0, issue = 0, taken_mul = 0, fall_mul = 0;
  logic [1:0] op = 0;
  logic [W-1:0] imm = 0, taken_imm = 0, fall_imm = 0;
  logic ready, done;
  logic [LANES-1:0] active_mask;
  logic [31:0] pass_total;
  logic [LANES*W-1:0] lanes;

  int checks = 0, errors = 0, cycles = 0;
  string tag = "R1";

  simt_branch_exec #(.LANES(LANES), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .imm(imm),
    .taken_mul(taken_mul), .taken_imm(taken_imm), .fall_mul(fall_mul), .fall_imm(fall_imm),
    .ready(ready), .done(done), .active_mask(active_mask), .pass_total(pass_total), .lanes(lanes));

  always #2 clk = ~clk;

  // behavioural reference model
  logic [W-1:0] m [LANES];
  logic m_busy, m_done, m_fmul;
  logic [W-1:0] m_fimm;
  logic [LANES-1:0] m_mask;
  int m_total;

  function automatic logic [W-1:0] calc(logic mul, logic [W-1:0] a, logic [W-1:0] k);
    if (mul) return W'(a * k);
    return W'(a + k);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LANES; i++) m[i] <= W'(i);
      m_busy <= 0; m_done <= 0; m_mask <= '1; m_total <= 0; m_fmul <= 0; m_fimm <= 0;
    end else if (m_busy) begin
      for (int i = 0; i < LANES; i++) if (m_mask[i]) m[i] <= calc(m_fmul, m[i], m_fimm);
      m_busy <= 0; m_done <= 1; m_mask <= '1; m_total <= m_total + 1;
    end else if (issue) begin
      int nt;
      nt = 0;
      for (int i = 0; i < LANES; i++) if (m[i] < imm) nt++;
      m_total <= m_total + 1;
      m_done <= 1;
      if (!op[1]) begin
        for (int i = 0; i < LANES; i++) m[i] <= calc(op[0], m[i], imm);
      end else if (nt == LANES) begin
        for (int i = 0; i < LANES; i++) m[i] <= calc(taken_mul, m[i], taken_imm);
      end else if (nt == 0) begin
        for (int i = 0; i < LANES; i++) m[i] <= calc(fall_mul, m[i], fall_imm);
      end else begin
        for (int i = 0; i < LANES; i++) begin
          if (m[i] < imm) m[i] <= calc(taken_mul, m[i], taken_imm);
          m_mask[i] <= !(m[i] < imm);
        end
        m_busy <= 1; m_done <= 0; m_fmul <= fall_mul; m_fimm <= fall_imm;
      end
    end else m_done <= 0;
  end

  task automatic check(string t, logic [63:0] act, logic [63:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected < 100000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (rst_n) begin
      for (int i = 0; i < LANES; i++) check(tag, lanes[i*W +: W], m[i], "lane");
      check(tag, ready, !m_busy, "ready");
      check(tag, done, m_done, "done");
      check("R8", active_mask, m_mask, "mask");
      check("R9", pass_total, m_total, "pass_total");
    end
  end

  task automatic send(logic [1:0] o, logic [W-1:0] k, logic tm, logic [W-1:0] ti, logic fm, logic [W-1:0] fi);
    @(negedge clk);
    op = o; imm = k; taken_mul = tm; taken_imm = ti; fall_mul = fm; fall_imm = fi; issue = 1;
    @(negedge clk);
    issue = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    tag = "R1";
    for (int i = 0; i < LANES; i++) check("R1", lanes[i*W +: W], i, "reset lane");
    check("R1", {ready, done, active_mask}, {1'b1, 1'b0, 8'hFF}, "reset flags");
    check("R1", pass_total, 0, "reset count");

    tag = "R2"; send(2'b00, 32'd5, 0, 0, 0, 0);
    check("R2", lanes[3*W +: W], 8, "add lane3");
    check("R2", done, 1, "add done");
    tag = "R3"; send(2'b01, 32'd3, 0, 0, 0, 0);
    check("R3", lanes[7*W +: W], 36, "mul lane7");
    send(2'b01, 32'h8000_0000, 0, 0, 0, 0);
    check("R3", lanes[1*W +: W], 0, "mul wrap lane1");
    check("R3", lanes[0*W +: W], 32'h8000_0000, "mul wrap lane0");

    do_reset(); @(negedge clk);
    tag = "R6"; base = pass_total;
    send(2'b10, 32'd4, 0, 32'd100, 1, 32'd2);
    check("R6", ready, 0, "busy after first pass");
    check("R8", active_mask, 8'hF0, "second pass mask");
    check("R7", lanes[5*W +: W], 5, "false lane held in first pass");
    check("R6", lanes[2*W +: W], 102, "taken lane after first pass");
    @(negedge clk);
    check("R6", done, 1, "done after second pass");
    for (int i = 0; i < LANES; i++)
      check("R6", lanes[i*W +: W], (i < 4) ? i + 100 : 2 * i, "divergent result");
    check("R9", pass_total - base, 2, "divergent pass count");

    tag = "R4"; base = pass_total;
    send(2'b11, 32'hFFFF_FFFF, 0, 32'd1, 1, 32'd9);
    check("R4", lanes[0*W +: W], 101, "uniform true lane0");
    check("R4", ready, 1, "uniform true single pass");
    check("R9", pass_total - base, 1, "uniform true count");

    tag = "R5"; base = pass_total;
    send(2'b10, 32'd0, 0, 32'd50, 1, 32'd3);
    check("R5", lanes[4*W +: W], 27, "uniform false lane4");
    check("R5", ready, 1, "uniform false single pass");
    check("R9", pass_total - base, 1, "uniform false count");

    do_reset(); @(negedge clk);
    tag = "R10"; base = pass_total;
    @(negedge clk);
    op = 2'b10; imm = 32'd2; taken_mul = 0; taken_imm = 32'd7; fall_mul = 0; fall_imm = 32'd1000; issue = 1;
    @(negedge clk);
    op = 2'b00; imm = 32'd1;
    @(negedge clk);
    issue = 0;
    check("R10", lanes[0*W +: W], 7, "ignored issue lane0");
    check("R10", lanes[6*W +: W], 1006, "ignored issue lane6");
    check("R10", pass_total - base, 2, "ignored issue count");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule